// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier with Paired-Bit Test Mode

This block is a synthesizable behavioural stand-in for an asynchronous-strobe DRAM, meant to sit inside the testbench of a memory controller. All strobes are active low and are sampled on the rising edge of a system clock. The block finds their edges and decides from the order of those edges what kind of memory cycle the controller ran. Each completed cycle is reported as a 3-bit code, one clock after the row strobe is seen to rise. A small array, sized by parameters, holds the data, so reads, writes and read-modify-writes give results that can be checked.

Seven kinds of cycle are told apart: plain reads, including page-mode reads with several column strobes under one row strobe; early writes; read-modify-writes; row-only refresh; column-before-row refresh; hidden refresh, where the column strobe stays low from a preceding read; and a column-before-row cycle with the write strobe low. That last cycle latches a parallel test mode. In test mode the lowest column address bit is ignored. A write stores the same word at both columns of the pair. A read returns, on each data pin, a 1 when the two stored bits agree and a 0 when they differ. That read result arrives one clock later than a normal read. A row-only refresh or a column-before-row refresh with the write strobe high leaves test mode.

Top module: `dram_cycle_model`

## Requirements
- R1: After reset, cycleValid is 0, testMode is 0 and dqOe is 0.
- R2: If weN is low in the clock where casN is first sampled low inside a row-strobe-low access, the cycle is an early write. dqIn is stored at address {row, column}, dqOe stays 0 for that column access, and the cycle is reported as code 1.
- R3: A read (weN high at the column strobe's fall) puts the stored word on dqOut in the clock after the one that samples casN falling. dqOe is high while oeN is low and the data is valid. The data is dropped in the clock after the one that samples casN rising. Several column strobes inside one row strobe each read their own column. A read cycle is reported as code 0.
- R4: If weN falls while casN stays low after a read in the same column strobe, the cycle is a read-modify-write. dqIn is stored at the column latched by that read, dqOut keeps the old word, and the cycle is reported as code 2.
- R5: A row-strobe-low period with no column strobe fall is reported as code 3 (row-only refresh), and testMode is 0 afterwards.
- R6: casN low and weN high when rasN falls, with casN having fallen while rasN was high, is reported as code 4 (column-before-row refresh). It clears testMode.
- R7: The same ordering with weN low is reported as code 5 and sets testMode. testMode stays set across later reads and writes.
- R8: In test mode a read ignores column bit 0. Each dqOut bit is 1 when the two words at column bit 0 = 0 and 1 agree in that bit, and 0 when they differ. The result is valid one clock later than in R3.
- R9: In test mode a write stores dqIn at both columns that differ only in bit 0.
- R10: If casN has stayed low since a read and rasN falls again, the cycle is reported as code 6 (hidden refresh). The read data stays on dqOut throughout, and testMode is unchanged.
- R11: A column-strobe fall inside a refresh cycle (one entered with casN already low) is reported as code 7 (illegal ordering).
- R12: cycleValid is high for exactly one clock: the clock after the one that samples rasN rising. cycleType holds the code of the cycle just ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dqIn | input | DQ_W | Write data |
| dqOut | output | DQ_W | Read data or test-mode compare result |
| dqOe | output | 1 | High when dqOut is driven |
| cycleType | output | 3 | Code of the last completed cycle |
| cycleValid | output | 1 | One-clock pulse when cycleType is updated |
| testMode | output | 1 | Latched parallel test mode |

## Verification
The bench changes inputs just after a falling clock edge and reads outputs at the following falling edge. One rising edge therefore lies between a stimulus and each sample. Normal read data and the cycle code are due one sample after the strobe change that causes them, so they are checked at that sample. Test-mode read data is due one sample later still. The bench checks that dqOe is still low at the first sample and checks the data at the second. Hidden-refresh checks sample dqOut while the row strobe is cycled again, to show that the earlier read data is held.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [2:0] {
    CY_READ    = 3'd0,
    CY_EWRITE  = 3'd1,
    CY_RMW     = 3'd2,
    CY_RASONLY = 3'd3,
    CY_CBR     = 3'd4,
    CY_TESTIN  = 3'd5,
    CY_HIDDEN  = 3'd6,
    CY_BAD     = 3'd7
  } cycle_e;

  typedef struct packed {
    logic rowLatch;
    logic rdStart;
    logic wrEarly;
    logic wrRmw;
    logic dqDrop;
    logic test;
  } strobe_t;

endpackage

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
  import dcm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  output strobe_t stb,
  output cycle_e  cycleType,
  output logic    cycleValid,
  output logic    testMode
);

  logic rasQ, casQ, weQ;
  logic refCycle, sawCas, badSeq, hiddenArm, readThisCas;
  cycle_e refKind, accKind;

  logic rasFall, rasRise, rasLow, casFall, casRise, weFall;

  always_comb begin
    rasFall = rasQ & ~rasN;
    rasRise = ~rasQ & rasN;
    rasLow  = ~rasQ & ~rasN;
    casFall = casQ & ~casN;
    casRise = ~casQ & casN;
    weFall  = weQ & ~weN;

    stb.rowLatch = rasFall & casN;
    stb.rdStart  = rasLow & ~refCycle & casFall & weN;
    stb.wrEarly  = rasLow & ~refCycle & casFall & ~weN;
    stb.wrRmw    = rasLow & ~refCycle & weFall & ~casN & ~casFall & readThisCas;
    stb.dqDrop   = casRise;
    stb.test     = testMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasQ        <= 1'b1;
      casQ        <= 1'b1;
      weQ         <= 1'b1;
      refCycle    <= 1'b0;
      refKind     <= CY_CBR;
      sawCas      <= 1'b0;
      accKind     <= CY_READ;
      badSeq      <= 1'b0;
      hiddenArm   <= 1'b0;
      readThisCas <= 1'b0;
      testMode    <= 1'b0;
      cycleType   <= CY_READ;
      cycleValid  <= 1'b0;
    end else begin
      rasQ       <= rasN;
      casQ       <= casN;
      weQ        <= weN;
      cycleValid <= 1'b0;

      if (casRise) begin
        hiddenArm   <= 1'b0;
        readThisCas <= 1'b0;
      end

      if (rasFall) begin
        badSeq  <= 1'b0;
        sawCas  <= 1'b0;
        accKind <= CY_READ;
        if (!casN) begin
          refCycle <= 1'b1;
          if (hiddenArm) begin
            refKind <= CY_HIDDEN;
          end else if (weN) begin
            refKind  <= CY_CBR;
            testMode <= 1'b0;
          end else begin
            refKind  <= CY_TESTIN;
            testMode <= 1'b1;
          end
        end else begin
          refCycle <= 1'b0;
        end
      end else if (rasLow) begin
        if (refCycle && casFall) badSeq <= 1'b1;
        if (!refCycle && casFall) begin
          sawCas    <= 1'b1;
          hiddenArm <= 1'b1;
          if (!weN) begin
            accKind <= CY_EWRITE;
          end else begin
            accKind     <= CY_READ;
            readThisCas <= 1'b1;
          end
        end
        if (stb.wrRmw) accKind <= CY_RMW;
      end else if (rasRise) begin
        cycleValid <= 1'b1;
        if (refCycle)    cycleType <= badSeq ? CY_BAD : refKind;
        else if (sawCas) cycleType <= accKind;
        else             cycleType <= CY_RASONLY;
        if (!refCycle && !sawCas) testMode <= 1'b0;
        refCycle <= 1'b0;
      end
    end
  end

  AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (rasFall && !casN && !weN && !hiddenArm) |=> testMode); // R7
  AST_CBR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rasFall && !casN && weN && !hiddenArm) |=> !testMode); // R6
  AST_RASONLY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && cycleType == CY_RASONLY) |-> !testMode); // R5
  AST_REPORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |=> !cycleValid); // R12
  AST_HIDDEN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (rasFall && !casN && hiddenArm) |=> (testMode == $past(testMode))); // R10

endmodule

// File: rtl/dcm_data.sv
module dcm_data
  import dcm_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DQ_W   = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe
);

  localparam int AW    = ROW_W + COL_W;
  localparam int DEPTH = 1 << AW;

  logic [DQ_W-1:0]  mem [DEPTH];
  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic [DQ_W-1:0]  rdData;
  logic             dqValid, rdPend;

  logic [COL_W-1:0] rdCol, wCol;
  logic [DQ_W-1:0]  wordN, wordLo, wordHi;
  logic             wrAny;

  always_comb begin
    rdCol  = addr[COL_W-1:0];
    wCol   = stb.wrEarly ? addr[COL_W-1:0] : colQ;
    wrAny  = stb.wrEarly | stb.wrRmw;
    wordN  = mem[{rowQ, rdCol}];
    wordLo = mem[{rowQ, rdCol[COL_W-1:1], 1'b0}];
    wordHi = mem[{rowQ, rdCol[COL_W-1:1], 1'b1}];
  end

  always_ff @(posedge clk) begin
    if (wrAny) begin
      if (stb.test) begin
        mem[{rowQ, wCol[COL_W-1:1], 1'b0}] <= dqIn;
        mem[{rowQ, wCol[COL_W-1:1], 1'b1}] <= dqIn;
      end else begin
        mem[{rowQ, wCol}] <= dqIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ    <= '0;
      colQ    <= '0;
      rdData  <= '0;
      dqValid <= 1'b0;
      rdPend  <= 1'b0;
    end else begin
      if (stb.rowLatch) rowQ <= addr[ROW_W-1:0];
      if (stb.rdStart || stb.wrEarly) colQ <= addr[COL_W-1:0];

      if (stb.dqDrop) begin
        dqValid <= 1'b0;
        rdPend  <= 1'b0;
      end else if (stb.rdStart) begin
        rdData  <= stb.test ? ~(wordLo ^ wordHi) : wordN;
        dqValid <= ~stb.test;
        rdPend  <= stb.test;
      end else if (stb.wrEarly) begin
        dqValid <= 1'b0;
        rdPend  <= 1'b0;
      end else if (rdPend) begin
        dqValid <= 1'b1;
        rdPend  <= 1'b0;
      end
    end
  end

  assign dqOut = rdData;
  assign dqOe  = dqValid & ~oeN;

  AST_EW_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEarly |=> !dqValid); // R2
  AST_NORM_READ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStart && !stb.test) |=> dqValid); // R3
  AST_CAS_DROP: assert property (@(posedge clk) disable iff (!rstN)
    stb.dqDrop |=> !dqValid); // R3
  AST_TEST_LATE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStart && stb.test) |=> !dqValid); // R8

endmodule

// File: rtl/dram_cycle_model.sv
module dram_cycle_model
  import dcm_pkg::*;
#(
  parameter  int ROW_W  = 3,
  parameter  int COL_W  = 3,
  parameter  int DQ_W   = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic [2:0]        cycleType,
  output logic              cycleValid,
  output logic              testMode
);

  strobe_t stb;
  cycle_e  cycleCode;

  dcm_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .stb        (stb),
    .cycleType  (cycleCode),
    .cycleValid (cycleValid),
    .testMode   (testMode)
  );

  dcm_data #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DQ_W   (DQ_W),
    .ADDR_W (ADDR_W)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .oeN   (oeN),
    .addr  (addr),
    .dqIn  (dqIn),
    .dqOut (dqOut),
    .dqOe  (dqOe)
  );

  assign cycleType = cycleCode;

  AST_ONE_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |-> $past(rasN)); // R12

endmodule

// File: tb/tb_dram_cycle_model.sv
module tb_dram_cycle_model;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rasN, casN, weN, oeN;
  logic [2:0] addr;
  logic [3:0] dqIn;
  logic [3:0] dqOut;
  logic       dqOe;
  logic [2:0] cycleType;
  logic       cycleValid;
  logic       testMode;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #5 clk = ~clk;

  dram_cycle_model dut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe),
    .cycleType(cycleType), .cycleValid(cycleValid), .testMode(testMode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic endCycle(input logic [2:0] code, input string req);
    rasN = 1'b1; step();
    chk({req, " R12 valid"}, {7'd0, cycleValid}, 8'd1);
    chk({req, " code"}, {5'd0, cycleType}, {5'd0, code});
    step();
    chk("R12 pulse ends", {7'd0, cycleValid}, 8'd0);
  endtask

  task automatic doWrite(input logic [2:0] row, input logic [2:0] col, input logic [3:0] d);
    addr = row; rasN = 1'b0; step();
    addr = col; weN = 1'b0; dqIn = d; casN = 1'b0; oeN = 1'b0; step();
    chk("R2 early write keeps DQ off", {7'd0, dqOe}, 8'd0);
    casN = 1'b1; weN = 1'b1; oeN = 1'b1; step();
    endCycle(3'd1, "R2 early write");
  endtask

  task automatic doRead(input logic [2:0] row, input logic [2:0] col,
                        input logic [3:0] exp, input bit tm, input string req);
    addr = row; rasN = 1'b0; step();
    addr = col; casN = 1'b0; oeN = 1'b0; step();
    if (tm) begin
      chk("R8 test read one clock late", {7'd0, dqOe}, 8'd0);
      step();
    end
    chk({req, " dqOe"}, {7'd0, dqOe}, 8'd1);
    chk({req, " data"}, {4'd0, dqOut}, {4'd0, exp});
    casN = 1'b1; oeN = 1'b1; step();
    chk("R3 data dropped after CAS rise", {7'd0, dqOe}, 8'd0);
    endCycle(3'd0, "R3 read");
  endtask

  task automatic doPage();
    addr = 3'd1; rasN = 1'b0; step();
    addr = 3'd2; casN = 1'b0; oeN = 1'b0; step();
    chk("R3 page first column", {4'd0, dqOut}, 8'h05);
    casN = 1'b1; step();
    addr = 3'd3; casN = 1'b0; step();
    chk("R3 page second column", {4'd0, dqOut}, 8'h0A);
    casN = 1'b1; oeN = 1'b1; step();
    endCycle(3'd0, "R3 page read");
  endtask

  task automatic doRmw(input logic [2:0] row, input logic [2:0] col,
                       input logic [3:0] oldD, input logic [3:0] newD);
    addr = row; rasN = 1'b0; step();
    addr = col; casN = 1'b0; oeN = 1'b0; step();
    chk("R4 old data out", {4'd0, dqOut}, {4'd0, oldD});
    oeN = 1'b1; weN = 1'b0; dqIn = newD; step();
    chk("R4 output keeps old word", {4'd0, dqOut}, {4'd0, oldD});
    weN = 1'b1; casN = 1'b1; step();
    endCycle(3'd2, "R4 rmw");
  endtask

  task automatic doRasOnly();
    addr = 3'd5; rasN = 1'b0; step();
    step();
    endCycle(3'd3, "R5 ras-only");
    chk("R5 test mode cleared", {7'd0, testMode}, 8'd0);
  endtask

  task automatic doCbr(input logic weLevel);
    casN = 1'b0; weN = weLevel; step();
    rasN = 1'b0; step();
    weN = 1'b1; step();
    step();
    if (weLevel) endCycle(3'd4, "R6 cbr");
    else         endCycle(3'd5, "R7 test entry");
    chk(weLevel ? "R6 test mode off" : "R7 test mode on",
        {7'd0, testMode}, {7'd0, ~weLevel});
    casN = 1'b1; step();
    step();
  endtask

  task automatic doHidden(input logic [2:0] row, input logic [2:0] col,
                          input logic [3:0] exp, input bit tm);
    addr = row; rasN = 1'b0; step();
    addr = col; casN = 1'b0; oeN = 1'b0; step();
    if (tm) step();
    chk("R10 read before hidden", {4'd0, dqOut}, {4'd0, exp});
    endCycle(3'd0, "R10 read part");
    rasN = 1'b0; step();
    chk("R10 data held dqOe", {7'd0, dqOe}, 8'd1);
    chk("R10 data held value", {4'd0, dqOut}, {4'd0, exp});
    step();
    endCycle(3'd6, "R10 hidden");
    chk("R10 test mode unchanged", {7'd0, testMode}, {7'd0, tm});
    chk("R10 data still held", {4'd0, dqOut}, {4'd0, exp});
    casN = 1'b1; oeN = 1'b1; step();
    step();
  endtask

  task automatic doIllegal();
    casN = 1'b0; step();
    rasN = 1'b0; step();
    casN = 1'b1; step();
    casN = 1'b0; step();
    endCycle(3'd7, "R11 illegal");
    casN = 1'b1; step();
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; rasN = 1'b1; casN = 1'b1; weN = 1'b1; oeN = 1'b1;
    addr = '0; dqIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; step();
    chk("R1 cycleValid", {7'd0, cycleValid}, 8'd0);
    chk("R1 testMode", {7'd0, testMode}, 8'd0);
    chk("R1 dqOe", {7'd0, dqOe}, 8'd0);

    doWrite(3'd1, 3'd2, 4'h5);
    doWrite(3'd1, 3'd3, 4'hA);
    doWrite(3'd6, 3'd7, 4'hC);
    doRead(3'd1, 3'd2, 4'h5, 1'b0, "R3 read a");
    doRead(3'd1, 3'd3, 4'hA, 1'b0, "R3 read b");
    doPage();
    doRmw(3'd6, 3'd7, 4'hC, 4'h3);
    doRead(3'd6, 3'd7, 4'h3, 1'b0, "R4 rmw stored");
    doRasOnly();
    doCbr(1'b1);

    doWrite(3'd2, 3'd6, 4'h9);
    doWrite(3'd2, 3'd7, 4'hA);
    doCbr(1'b0);
    doRead(3'd2, 3'd6, 4'hC, 1'b1, "R8 compare even");
    doRead(3'd2, 3'd7, 4'hC, 1'b1, "R8 bit0 ignored");
    doWrite(3'd2, 3'd4, 4'h7);
    doRead(3'd2, 3'd5, 4'hF, 1'b1, "R9 pair equal");
    doHidden(3'd2, 3'd4, 4'hF, 1'b1);
    doRasOnly();
    doRead(3'd2, 3'd4, 4'h7, 1'b0, "R9 even column");
    doRead(3'd2, 3'd5, 4'h7, 1'b0, "R9 odd column");
    doHidden(3'd1, 3'd3, 4'hA, 1'b0);
    doCbr(1'b0);
    doCbr(1'b1);
    doIllegal();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule